// File: doc/BRIEF.md
# Register-Pattern Read Burst Generator

This block models the device side of a DDR3-style memory while it is in register-read mode. A read command is accepted together with column address bits 2..0, the chop-select address bit and the current mode settings. After the programmed read latency, the block returns an 8-bit register pattern over a 16-bit data bus, one register bit per beat.

The pattern bit for each beat appears on bit 0 of both byte lanes. The other seven lines of each lane either copy that bit or stay at zero. In a chopped burst, column bit 2 selects which half of the pattern is sent. Commands that are illegal, or that arrive while the DLL is not locked, are refused with a one-cycle error pulse and produce no data.

The capture runs one data beat per clock. A command that arrives while a burst is being driven waits in a short queue. It starts on the clock right after the current burst ends.

Top module: `mpr_burst_gen`

## Requirements
- R1: During every beat of a burst, bit 0 of the lower lane (dq[7:0]) carries the current pattern bit, and the upper lane dq[15:8] always equals the lower lane.
- R2: When `replicate` is 1 at the command, dq[7:1] of each lane copy lane bit 0. When it is 0, dq[7:1] are 0 on every beat.
- R3: A read command with colAddr[1:0] not equal to 2'b00 makes `mprErr` high for exactly the cycle after the command edge, and no data beat is produced.
- R4: A full burst gives 8 beats carrying pattern bits 0,1,...,7, least significant bit first. A full-burst command with colAddr[2]=1 is refused as in R3.
- R5: A chopped burst gives 4 beats. colAddr[2]=0 sends pattern bits 0..3 and colAddr[2]=1 sends bits 4..7, lowest first.
- R6: blMode 2'b00 fixes full bursts and 2'b01 fixes chopped bursts. With blMode 2'b10 or 2'b11, the burst length is chosen per command: `a12Bc` low chops and high gives a full burst.
- R7: A command accepted at clock edge n shows its first beat after edge n+L, where L is `readLat` clamped into the range 5..14.
- R8: A read command while `dllLocked` is 0 is refused: `mprErr` pulses the following cycle and no data is produced.
- R9: After reset and outside bursts, dq is 0 and `dqValid` is 0. `dqValid` is 1 exactly on data beats.
- R10: Accepted commands leave in order. A command whose latency expires during a running burst starts on the beat right after that burst's last beat. At most 4 commands can wait. A command that finds 4 waiting is refused as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rdCmd | input | 1 | Register-read command strobe |
| colAddr | input | 3 | Column address bits 2..0 |
| a12Bc | input | 1 | Per-command chop select (low = chop) |
| blMode | input | 2 | Burst length mode: 00 full, 01 chop, 1x per command |
| readLat | input | 4 | Read latency in clocks (clamped 5..14) |
| replicate | input | 1 | 1: copy lane bit 0 to bits 7:1, 0: drive them low |
| dllLocked | input | 1 | DLL lock indication |
| regData | input | 8 | Selected register pattern |
| dq | output | 16 | Data bus, two byte lanes |
| dqValid | output | 1 | High on each data beat |
| mprErr | output | 1 | One-cycle pulse for a refused command |

## Verification
The bench builds the block with its default parameters: a four-entry queue, a latency range of 5 to 14 and an 8-bit pattern. These values bring clamping at both latency bounds within reach of a few commands, along with queue saturation (five full bursts at latency 14) and back-to-back chaining at minimum latency. A behavioural model assigns every accepted command its start cycle and compares the data bus, valid strobe and error flag on each clock.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    BL_FULL    = 2'b00,
    BL_CHOP    = 2'b01,
    BL_OTF     = 2'b10,
    BL_OTF_ALT = 2'b11
  } blMode_e;

  typedef struct packed {
    logic             load;
    logic             shift;
    logic             clear;
    logic [REG_W-1:0] bits;
    logic             rep;
  } beatStrobe_t;
endpackage

// File: rtl/mpr_ctrl.sv
module mpr_ctrl
  import mpr_pkg::*;
#(
  parameter int QDEPTH  = 4,
  parameter int LAT_W   = 4,
  parameter int LAT_MIN = 5,
  parameter int LAT_MAX = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdCmd,
  input  logic [2:0]       colAddr,
  input  logic             a12Bc,
  input  logic [1:0]       blMode,
  input  logic [LAT_W-1:0] readLat,
  input  logic             replicate,
  input  logic             dllLocked,
  input  logic [REG_W-1:0] regData,
  output beatStrobe_t      strobe,
  output logic             errFlag
);
  localparam int PTR_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CNT_W  = $clog2(QDEPTH + 1);
  localparam int HALF   = REG_W / 2;
  localparam int BEAT_W = $clog2(REG_W + 1);

  logic [REG_W-1:0] slotBits [QDEPTH];
  logic             slotRep  [QDEPTH];
  logic             slotChop [QDEPTH];
  logic [LAT_W-1:0] slotWait [QDEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;
  logic [BEAT_W-1:0] beatsLeft;

  logic chopSel, badAddr, qFull, reject, accept, headReady, pop;
  logic [REG_W-1:0] orderedBits;
  logic [LAT_W-1:0] latClamped;

  always_comb begin
    chopSel = (blMode == BL_CHOP) | (blMode[1] & ~a12Bc);
    badAddr = (colAddr[1:0] != 2'b00) | (~chopSel & colAddr[2]);
    qFull   = (count == CNT_W'(QDEPTH));
    reject  = rdCmd & (badAddr | ~dllLocked | qFull);
    accept  = rdCmd & ~reject;
    orderedBits = (chopSel & colAddr[2]) ? (regData >> HALF) : regData;
    if (readLat < LAT_W'(LAT_MIN))      latClamped = LAT_W'(LAT_MIN);
    else if (readLat > LAT_W'(LAT_MAX)) latClamped = LAT_W'(LAT_MAX);
    else                                latClamped = readLat;
  end

  assign headReady = (count != '0) && (slotWait[rdPtr] == '0);
  assign pop       = headReady && (beatsLeft <= BEAT_W'(1));

  always_comb begin
    strobe.load  = pop;
    strobe.shift = beatsLeft > BEAT_W'(1);
    strobe.clear = (beatsLeft == BEAT_W'(1)) && !pop;
    strobe.bits  = slotBits[rdPtr];
    strobe.rep   = slotRep[rdPtr];
  end

  genvar gi;
  generate
    for (gi = 0; gi < QDEPTH; gi++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rstN) begin
          slotBits[gi] <= '0;
          slotRep[gi]  <= 1'b0;
          slotChop[gi] <= 1'b0;
          slotWait[gi] <= '0;
        end else if (accept && wrPtr == PTR_W'(gi)) begin
          slotBits[gi] <= orderedBits;
          slotRep[gi]  <= replicate;
          slotChop[gi] <= chopSel;
          slotWait[gi] <= latClamped - LAT_W'(1);
        end else if (slotWait[gi] != '0) begin
          slotWait[gi] <= slotWait[gi] - LAT_W'(1);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr     <= '0;
      wrPtr     <= '0;
      count     <= '0;
      beatsLeft <= '0;
      errFlag   <= 1'b0;
    end else begin
      errFlag <= reject;
      if (accept) wrPtr <= (wrPtr == PTR_W'(QDEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      if (pop)    rdPtr <= (rdPtr == PTR_W'(QDEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
      case ({accept, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      if (pop)                  beatsLeft <= slotChop[rdPtr] ? BEAT_W'(HALF) : BEAT_W'(REG_W);
      else if (beatsLeft != '0) beatsLeft <= beatsLeft - BEAT_W'(1);
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(QDEPTH));
  p_addr_error_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdCmd && colAddr[1:0] != 2'b00) |=> errFlag);
  p_dll_error_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdCmd && !dllLocked) |=> errFlag);
  p_full_a2_error_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdCmd && blMode == BL_FULL && colAddr[2]) |=> errFlag);
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.shift, strobe.clear}));
endmodule

// File: rtl/mpr_datapath.sv
module mpr_datapath
  import mpr_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  beatStrobe_t             strobe,
  output logic [LANES*LANE_W-1:0] dq,
  output logic                    dqValid
);
  logic [REG_W-1:0]  shiftReg;
  logic              repQ;
  logic              beatBit;
  logic [LANE_W-1:0] laneVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      repQ     <= 1'b0;
      beatBit  <= 1'b0;
      dqValid  <= 1'b0;
    end else if (strobe.load) begin
      shiftReg <= strobe.bits >> 1;
      repQ     <= strobe.rep;
      beatBit  <= strobe.bits[0];
      dqValid  <= 1'b1;
    end else if (strobe.shift) begin
      shiftReg <= shiftReg >> 1;
      beatBit  <= shiftReg[0];
    end else if (strobe.clear) begin
      beatBit  <= 1'b0;
      dqValid  <= 1'b0;
    end
  end

  assign laneVal = repQ ? {LANE_W{beatBit}} : {{(LANE_W-1){1'b0}}, beatBit};

  genvar gl;
  generate
    for (gl = 0; gl < LANES; gl++) begin : g_lane
      assign dq[gl*LANE_W +: LANE_W] = laneVal;
    end
  endgenerate

  p_load_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> dqValid);
  p_shift_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> dqValid);
  p_clear_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (!dqValid && dq == '0));
endmodule

// File: rtl/mpr_burst_gen.sv
module mpr_burst_gen
  import mpr_pkg::*;
#(
  parameter int QDEPTH  = 4,
  parameter int LAT_W   = 4,
  parameter int LAT_MIN = 5,
  parameter int LAT_MAX = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdCmd,
  input  logic [2:0]       colAddr,
  input  logic             a12Bc,
  input  logic [1:0]       blMode,
  input  logic [LAT_W-1:0] readLat,
  input  logic             replicate,
  input  logic             dllLocked,
  input  logic [7:0]       regData,
  output logic [15:0]      dq,
  output logic             dqValid,
  output logic             mprErr
);
  beatStrobe_t strobe;

  mpr_ctrl #(
    .QDEPTH(QDEPTH), .LAT_W(LAT_W), .LAT_MIN(LAT_MIN), .LAT_MAX(LAT_MAX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rdCmd(rdCmd), .colAddr(colAddr), .a12Bc(a12Bc),
    .blMode(blMode), .readLat(readLat), .replicate(replicate),
    .dllLocked(dllLocked), .regData(regData), .strobe(strobe), .errFlag(mprErr)
  );

  mpr_datapath #(.LANES(2), .LANE_W(8)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dq(dq), .dqValid(dqValid)
  );
endmodule

// File: tb/sim_mpr_burst_gen.sv
`timescale 1ns/1ps
module sim_mpr_burst_gen;
  logic clk = 1'b0;
  logic rstN, rdCmd, a12Bc, replicate, dllLocked;
  logic [2:0] colAddr;
  logic [1:0] blMode;
  logic [3:0] readLat;
  logic [7:0] regData;
  logic [15:0] dq;
  logic dqValid, mprErr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lastEnd = -100;
  logic [15:0] expDq [int];
  string expTag [int];
  string errTag [int];
  int pend [$];

  always #2.5 clk = ~clk;

  mpr_burst_gen u0 (
    .clk(clk), .rstN(rstN), .rdCmd(rdCmd), .colAddr(colAddr), .a12Bc(a12Bc),
    .blMode(blMode), .readLat(readLat), .replicate(replicate),
    .dllLocked(dllLocked), .regData(regData), .dq(dq), .dqValid(dqValid),
    .mprErr(mprErr)
  );

  task automatic check_now();
    logic [15:0] eDq;
    logic eV, eE;
    string t, te;
    eV  = expDq.exists(cyc);
    eDq = eV ? expDq[cyc] : 16'h0;
    t   = eV ? expTag[cyc] : "R9";
    eE  = errTag.exists(cyc);
    te  = eE ? errTag[cyc] : "R9";
    checks++;
    if (dq !== eDq || dqValid !== eV) begin
      errors++;
      $display("FAIL %s cyc %0d dq=%h valid=%b expected dq=%h valid=%b", t, cyc, dq, dqValid, eDq, eV);
    end
    checks++;
    if (mprErr !== eE) begin
      errors++;
      $display("FAIL %s cyc %0d mprErr=%b expected %b", te, cyc, mprErr, eE);
    end
  endtask

  task automatic step();
    @(posedge clk);
    cyc++;
    @(negedge clk);
    check_now();
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step();
  endtask

  function automatic void model(input int n, input logic [2:0] a, input logic a12,
      input logic [1:0] blm, input int rl, input logic rep, input logic [7:0] data,
      input logic dll, input string tag);
    int occ, rlc, start, len, base;
    logic chop, bad, b;
    logic [7:0] lane;
    occ = 0;
    foreach (pend[i]) if (pend[i] >= n) occ++;
    chop = (blm == 2'b01) || (blm[1] && !a12);
    bad  = (a[1:0] != 2'b00) || (!chop && a[2]) || !dll || (occ >= 4);
    if (bad) begin
      errTag[n] = tag;
      return;
    end
    rlc   = (rl < 5) ? 5 : ((rl > 14) ? 14 : rl);
    start = (n + rlc > lastEnd + 1) ? n + rlc : lastEnd + 1;
    len   = chop ? 4 : 8;
    base  = (chop && a[2]) ? 4 : 0;
    for (int i = 0; i < len; i++) begin
      b    = data[base + i];
      lane = rep ? {8{b}} : {7'b0, b};
      expDq[start + i]  = {lane, lane};
      expTag[start + i] = tag;
    end
    lastEnd = start + len - 1;
    pend.push_back(start);
  endfunction

  task automatic cmd(input logic [2:0] a, input logic a12, input logic [1:0] blm,
      input int rl, input logic rep, input logic [7:0] data, input logic dll,
      input string tag);
    colAddr = a; a12Bc = a12; blMode = blm; readLat = 4'(rl);
    replicate = rep; regData = data; dllLocked = dll; rdCmd = 1'b1;
    model(cyc + 1, a, a12, blm, rl, rep, data, dll, tag);
    step();
    rdCmd = 1'b0;
    colAddr = 3'b111; a12Bc = 1'b0; regData = 8'hFF;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; rdCmd = 1'b0; colAddr = 3'b0; a12Bc = 1'b1; blMode = 2'b00;
    readLat = 4'd5; replicate = 1'b0; dllLocked = 1'b1; regData = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (dq !== 16'h0 || dqValid !== 1'b0 || mprErr !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset dq=%h valid=%b err=%b expected 0 0 0", dq, dqValid, mprErr);
    end
    rstN = 1'b1;
    cyc = 0;
    idle(2);
    // R1 R4: full burst, lines 7:1 zero
    cmd(3'b000, 1'b1, 2'b00, 5, 1'b0, 8'hA5, 1'b1, "R1");
    idle(16);
    // R2 R4: full burst with replication, longer latency (R7)
    cmd(3'b000, 1'b1, 2'b00, 7, 1'b1, 8'h3C, 1'b1, "R2");
    idle(18);
    // R5: fixed chop, lower and upper halves
    cmd(3'b000, 1'b0, 2'b01, 6, 1'b1, 8'h96, 1'b1, "R5");
    idle(12);
    cmd(3'b100, 1'b1, 2'b01, 6, 1'b0, 8'h96, 1'b1, "R5");
    idle(12);
    // R6: per-command chop selection
    cmd(3'b100, 1'b0, 2'b10, 5, 1'b1, 8'hC3, 1'b1, "R6");
    idle(12);
    cmd(3'b000, 1'b1, 2'b11, 5, 1'b0, 8'h5B, 1'b1, "R6");
    idle(15);
    // R3 R4: illegal addresses
    cmd(3'b001, 1'b1, 2'b00, 5, 1'b0, 8'hFF, 1'b1, "R3");
    cmd(3'b010, 1'b0, 2'b01, 5, 1'b0, 8'hFF, 1'b1, "R3");
    cmd(3'b100, 1'b1, 2'b00, 5, 1'b1, 8'hFF, 1'b1, "R4");
    cmd(3'b100, 1'b1, 2'b10, 5, 1'b1, 8'hFF, 1'b1, "R6");
    idle(15);
    // R8: DLL not locked
    cmd(3'b000, 1'b1, 2'b00, 5, 1'b1, 8'hFF, 1'b0, "R8");
    idle(15);
    // R7: latency clamping at both bounds
    cmd(3'b000, 1'b1, 2'b00, 2, 1'b0, 8'h81, 1'b1, "R7");
    idle(16);
    cmd(3'b000, 1'b1, 2'b00, 15, 1'b1, 8'h42, 1'b1, "R7");
    idle(26);
    // R10: chaining of bursts with no gap
    cmd(3'b000, 1'b1, 2'b00, 5, 1'b0, 8'hE7, 1'b1, "R10");
    idle(1);
    cmd(3'b100, 1'b0, 2'b10, 5, 1'b1, 8'h1E, 1'b1, "R10");
    cmd(3'b000, 1'b0, 2'b01, 5, 1'b0, 8'h69, 1'b1, "R10");
    idle(30);
    // R10: queue saturation, fifth command refused
    for (int i = 0; i < 5; i++)
      cmd(3'b000, 1'b1, 2'b00, 14, i[0], 8'h11 * (i + 1), 1'b1, "R10");
    idle(60);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule